// File: doc/BRIEF.md
# Multiply-Divide Busy Interlock

This block decides when a read of the HI or LO result registers must wait for the integer multiply/divide unit. Each time a multiply or divide issues, the block stores the absolute time at which the unit becomes free. That time is the current value of a free-running time base plus a fixed latency for the operation class. The latency does not depend on the operand data. A read of HI or LO stalls only for the part of that latency still outstanding when the read arrives, so independent instructions placed between the operation and the read hide its cost.

The time base moves forward only in cycles where the advance input is high. An issue counts only in an advancing cycle. The residual busy time is the stored free time minus the current time. A residual of the divide latency or more covers both negative values and stale deadlines after the time base wraps, and it is read as "no stall". A new operation always replaces the stored deadline. The arithmetic, the HI/LO storage and every other pipeline hazard live outside this block.

Top module: `muldiv_busy_interlock`

## Requirements
- R1: After reset `remain_o` is 0, and `stall_o` stays low even when a read is requested.
- R2: A multiply with `op_i` = 0 (signed) or 1 (unsigned) gives `remain_o` = 10 in the cycle after its issue edge. Each further advancing cycle lowers it by 1, and it reaches 0 eleven advancing cycles after the issue.
- R3: A divide with `op_i` = 2, or any other class (`op_i` = 3), gives `remain_o` = 36 after its issue edge. Each advancing cycle lowers it by 1, and it reaches 0 after 37 advancing cycles.
- R4: In a cycle with `adv_i` low, `remain_o` keeps its value.
- R5: `stall_o` is high exactly when either bit of `rd_req_i` is set (bit 0 reads HI, bit 1 reads LO) while `remain_o` is non-zero.
- R6: A read held by `stall_o` is released in the cycle where `remain_o` reaches 0. The number of stalled advancing cycles equals the residual that was left when the read arrived.
- R7: A new issue while the unit is busy replaces the old deadline. The residual becomes the new operation's latency minus one, whether that is shorter or longer than what was left.
- R8: Once a deadline has passed, `remain_o` stays 0 and no read stalls. A residual of 37 or more is treated as invalid and gives no stall.
- R9: A `start_i` pulse in a cycle with `adv_i` low has no effect on the deadline.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Multiply/divide issues this cycle |
| op_i | input | 2 | Operation class: 0 signed multiply, 1 unsigned multiply, 2 or 3 divide |
| adv_i | input | 1 | Pipeline advances this cycle |
| rd_req_i | input | 2 | Read request: bit 0 HI, bit 1 LO |
| stall_o | output | 1 | Hold the requesting read |
| remain_o | output | REM_W | Busy cycles left, 0 when free |

## Verification
Both multiply classes and both divide encodings are issued and followed cycle by cycle. This separates the two latencies and shows that class 3 falls back to the divide latency. Gaps with `adv_i` low between advancing cycles show that only advancing cycles count. Reads are placed at different distances from an issue: at the start, mid-way, after completion and long after completion. These cases separate a residual stall from a full-latency stall and show that expired deadlines are not stalled. Back-to-back issues in both orders of latency, and issues in non-advancing cycles, show that the deadline is replaced and that the advance qualifier is honoured.

// File: rtl/mdb_pkg.sv
package mdb_pkg;

  typedef enum logic [1:0] {
    MD_MUL_S   = 2'd0,
    MD_MUL_U   = 2'd1,
    MD_DIV     = 2'd2,
    MD_DIV_ALT = 2'd3
  } md_op_e;

  // Fixed latency per class; anything that is not a multiply takes the divide time
  function automatic int unsigned md_latency(md_op_e op, int unsigned mul_lat,
                                             int unsigned div_lat);
    case (op)
      MD_MUL_S, MD_MUL_U: return mul_lat;
      default:            return div_lat;
    endcase
  endfunction

endpackage

// File: rtl/mdb_timebase.sv
module mdb_timebase #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  output logic [CNT_W-1:0] now_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    now_o <= '0;
    else if (adv_i) now_o <= now_o + CNT_W'(1);
  end

endmodule

// File: rtl/mdb_deadline.sv
module mdb_deadline
  import mdb_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MUL_LAT = 11,
  parameter int DIV_LAT = 37
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  md_op_e           op_i,
  input  logic [CNT_W-1:0] now_i,
  output logic [CNT_W-1:0] free_o
);

  logic [CNT_W-1:0] lat;

  always_comb lat = CNT_W'(md_latency(op_i, MUL_LAT, DIV_LAT));

  // Absolute free time = issue time + latency; a later issue always overrides
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      free_o <= '0;
    else if (issue_i) free_o <= now_i + lat;
  end

endmodule

// File: rtl/mdb_residual.sv
module mdb_residual #(
  parameter int CNT_W   = 16,
  parameter int DIV_LAT = 37,
  parameter int REM_W   = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] free_i,
  input  logic [CNT_W-1:0] now_i,
  input  logic [1:0]       rd_req_i,
  output logic [REM_W-1:0] remain_o,
  output logic             stall_o
);

  logic [CNT_W-1:0] diff;
  logic             in_window;

  // Modular difference: past deadlines and stale values land at or above the limit
  always_comb begin
    diff      = free_i - now_i;
    in_window = diff < CNT_W'(DIV_LAT);
    remain_o  = in_window ? diff[REM_W-1:0] : '0;
    stall_o   = (|rd_req_i) && (remain_o != '0);
  end

  p_remain_bound_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remain_o < REM_W'(DIV_LAT));

  p_stall_needs_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> (rd_req_i != 2'b00));

endmodule

// File: rtl/muldiv_busy_interlock.sv
module muldiv_busy_interlock
  import mdb_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int MUL_LAT = 11,
  parameter int DIV_LAT = 37,
  parameter int REM_W   = $clog2(DIV_LAT)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [1:0]       op_i,
  input  logic             adv_i,
  input  logic [1:0]       rd_req_i,
  output logic             stall_o,
  output logic [REM_W-1:0] remain_o
);

  logic [CNT_W-1:0] now_q;
  logic [CNT_W-1:0] free_q;
  logic             issue;
  md_op_e           op_cls;

  always_comb begin
    issue  = start_i && adv_i;
    op_cls = md_op_e'(op_i);
  end

  mdb_timebase #(.CNT_W(CNT_W)) i_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv_i),
    .now_o  (now_q)
  );

  mdb_deadline #(.CNT_W(CNT_W), .MUL_LAT(MUL_LAT), .DIV_LAT(DIV_LAT)) i_deadline (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .issue_i (issue),
    .op_i    (op_cls),
    .now_i   (now_q),
    .free_o  (free_q)
  );

  mdb_residual #(.CNT_W(CNT_W), .DIV_LAT(DIV_LAT), .REM_W(REM_W)) i_residual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .free_i   (free_q),
    .now_i    (now_q),
    .rd_req_i (rd_req_i),
    .remain_o (remain_o),
    .stall_o  (stall_o)
  );

  p_mul_load_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && (op_i[1] == 1'b0)) |=> (remain_o == REM_W'(MUL_LAT - 1)));

  p_div_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue && op_i[1]) |=> (remain_o == REM_W'(DIV_LAT - 1)));

  p_countdown_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !start_i && (remain_o != '0)) |=> (remain_o == $past(remain_o) - REM_W'(1)));

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(remain_o));

  p_stays_free_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((remain_o == '0) && !issue) |=> (remain_o == '0));

endmodule

// File: tb/test_muldiv_busy_interlock.sv
`timescale 1ns/1ps
module test_muldiv_busy_interlock;

  localparam int  REM_W = 6;
  localparam time TCLK  = 4ns;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic [1:0]       op = 2'd0;
  logic             adv = 1'b0;
  logic [1:0]       rd_req = 2'b00;
  logic             stall;
  logic [REM_W-1:0] remain;

  int checks = 0;
  int errors = 0;

  always #(TCLK/2) clk = ~clk;

  muldiv_busy_interlock i_muldiv_busy_interlock (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .op_i     (op),
    .adv_i    (adv),
    .rd_req_i (rd_req),
    .stall_o  (stall),
    .remain_o (remain)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_rem(input string req, input int exp);
    check(int'(remain) == exp, req, int'(remain), exp);
  endtask

  task automatic chk_stall(input string req, input int exp);
    #1;
    check(int'(stall) == exp, req, int'(stall), exp);
  endtask

  // One clock with the given advance; sampled 1 ns after the edge
  task automatic tick(input bit a);
    adv = a;
    @(posedge clk);
    #1;
    start = 1'b0;
  endtask

  task automatic issue(input logic [1:0] o, input bit a);
    start = 1'b1;
    op = o;
    tick(a);
  endtask

  task automatic idle_out(input int n);
    for (int k = 0; k < n; k++) tick(1);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    rd_req = 2'b11;
    #(3*TCLK);
    chk_rem("R1 reset remain", 0);
    chk_stall("R1 reset stall", 0);
    rst_n = 1'b1;
    tick(1);
    chk_rem("R1 after release", 0);
    chk_stall("R1 no stall after release", 0);
    rd_req = 2'b00;
  endtask

  task automatic t_mul(input logic [1:0] o);
    bit ok = 1;
    issue(o, 1);
    chk_rem("R2 mul first", 10);
    for (int k = 9; k >= 0; k--) begin
      tick(1);
      if (int'(remain) != k) ok = 0;
    end
    check(ok, "R2 mul countdown", int'(remain), 0);
    tick(1);
    chk_rem("R2 mul done", 0);
  endtask

  task automatic t_div(input logic [1:0] o);
    issue(o, 1);
    chk_rem("R3 div first", 36);
    idle_out(20);
    chk_rem("R3 div mid", 16);
    idle_out(15);
    chk_rem("R3 div near", 1);
    tick(1);
    chk_rem("R3 div done", 0);
  endtask

  task automatic t_hold;
    issue(2'd0, 1);
    idle_out(3);
    chk_rem("R4 before gap", 7);
    for (int k = 0; k < 5; k++) tick(0);
    chk_rem("R4 held through gap", 7);
    tick(1);
    chk_rem("R4 resumes", 6);
    idle_out(10);
  endtask

  task automatic t_stall_read;
    int cnt = 0;
    issue(2'd2, 1);
    idle_out(20);
    rd_req = 2'b01;
    chk_stall("R5 HI read while busy", 1);
    while (stall && cnt < 100) begin
      tick(1);
      cnt++;
    end
    check(cnt == 16, "R6 stall length", cnt, 16);
    chk_rem("R6 released at zero", 0);
    rd_req = 2'b10;
    chk_stall("R5 LO read when free", 0);
    rd_req = 2'b00;
    issue(2'd1, 1);
    chk_stall("R5 no request no stall", 0);
    rd_req = 2'b10;
    chk_stall("R5 LO read while busy", 1);
    rd_req = 2'b00;
    idle_out(12);
  endtask

  task automatic t_restart;
    issue(2'd2, 1);
    idle_out(5);
    chk_rem("R7 div partial", 31);
    issue(2'd0, 1);
    chk_rem("R7 shortened by mul", 10);
    idle_out(4);
    issue(2'd3, 1);
    chk_rem("R7 extended by div", 36);
    idle_out(37);
    chk_rem("R7 done", 0);
  endtask

  task automatic t_expiry;
    bit ok = 1;
    issue(2'd1, 1);
    idle_out(11);
    rd_req = 2'b11;
    for (int k = 0; k < 300; k++) begin
      tick(1);
      if (remain != '0 || stall) ok = 0;
    end
    check(ok, "R8 stays free after deadline", int'(remain), 0);
    chk_stall("R8 no stall long after", 0);
    rd_req = 2'b00;
  endtask

  task automatic t_start_noadv;
    issue(2'd2, 0);
    chk_rem("R9 unqualified start idle", 0);
    tick(1);
    chk_rem("R9 still idle", 0);
    issue(2'd0, 1);
    idle_out(2);
    issue(2'd2, 0);
    chk_rem("R9 unqualified start busy", 8);
    tick(1);
    chk_rem("R9 old deadline kept", 7);
    idle_out(8);
  endtask

  initial begin
    #(TCLK*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_mul(2'd0);
    t_mul(2'd1);
    t_div(2'd2);
    t_div(2'd3);
    t_hold();
    t_stall_read();
    t_restart();
    t_expiry();
    t_start_noadv();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule